// File: doc/BRIEF.md
# SPI Master Shift Engine

This block turns parallel words into a serial SPI stream and collects the returning serial data into words. It takes words from an external transmit queue, shifts each one out most significant bit first on `mosi` while generating `sck`, samples `miso` on the same word, and offers the received word to an external receive queue. The bit rate comes from a 9-bit divider. Each half period of `sck` lasts `brg + 1` clock cycles, so the serial clock runs at the input clock divided by 2×(`brg`+1).

Software-visible controls arrive as plain inputs. They are a module-on bit, a master-mode bit, a 2-bit word-length code, the idle level of `sck`, the data-change edge, the input sample point and an automatic slave-select enable. The divider value, the word length and the three timing controls are captured when a word begins, so a change while a word is shifting takes effect only on the next word. When the transmit queue still holds a word at the end of the current one, the next word follows at once with no idle clock.

Top module: `spi_shift_engine`

## Requirements
- R1: Every `sck` half period of a word lasts exactly `brg`+1 clock cycles, using the `brg` value present in the cycle the word was popped; changing `brg` during a word does not alter that word's timing.
- R2: The word length code selects the bits per word: 0 gives 8, 1 gives 16, 2 gives 32, and 3 also gives 32; each word spans exactly 2×N half periods of `sck`, numbered 0 to 2N−1.
- R3: While `busy` is low, `sck` rests at the `cpol` level (1 = idle high).
- R4: In half period h of a word, `sck` equals `cpol` XOR (h mod 2) XOR NOT `cke`. So with `cke`=1 half 0 sits at the idle level, and with `cke`=0 `sck` moves to the active level at the start of every bit. `mosi` carries data bit N−1−⌊h/2⌋ (MSB first) throughout halves 2k and 2k+1.
- R5: With `smp`=0, bit k of the received word is `miso` as sampled at the clock edge that ends half 2k. With `smp`=1 it is sampled at the edge that ends half 2k+1. One cycle after the last half ends, `rx_push` pulses for one cycle and `rx_data` holds the N received bits, right aligned and MSB first, with the upper bits zero.
- R6: `tx_pop` pulses once per word, in the cycle whose clock edge starts it. If `tx_valid` is high when a word ends, the next word starts on that same edge and `busy` stays high. Otherwise `busy` falls.
- R7: With `auto_ss`=1, `ss_n` is low exactly while `busy` is high, and it stays low across back-to-back words. With `auto_ss`=0, `ss_n` stays high.
- R8: No word starts unless `on_en` and `master_mode` are both high. Dropping either one during a word aborts it: one cycle later `busy` is low, `sck` is idle and `ss_n` is high, and no `rx_push` is produced for the aborted word.
- R9: After reset, `busy`, `tx_pop` and `rx_push` are low, `ss_n` is high and `sck` equals `cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| on_en | input | 1 | Module on; low stops and clears any transfer |
| master_mode | input | 1 | Master mode; must be high for the engine to run |
| auto_ss | input | 1 | Drive `ss_n` automatically from word activity |
| cpol | input | 1 | Idle level of `sck` |
| cke | input | 1 | 1: data changes on the active-to-idle edge; 0: on the idle-to-active edge |
| smp | input | 1 | 1: sample `miso` at the end of the bit; 0: in the middle |
| wlen | input | 2 | Word length code (0: 8, 1: 16, 2 or 3: 32 bits) |
| brg | input | 9 | Baud divider; half period = `brg`+1 cycles |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_data | input | 32 | Word at the head of the transmit queue (low N bits used) |
| tx_pop | output | 1 | Take the head word from the transmit queue |
| rx_data | output | 32 | Received word, right aligned |
| rx_push | output | 1 | Write `rx_data` into the receive queue |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Slave select, active low |
| busy | output | 1 | A word is being shifted |

## Verification
The end of one word and the start of the next fall on the same clock edge whenever the transmit queue is non-empty at a word boundary. On that edge the engine pushes the finished received word, pops the new one, reloads the divider and, with `smp`=1, takes the final `miso` sample. The bench provokes this with two or three queued words, under both clock phases and at `brg` of 0, where every half period is a single cycle. A slave model in the bench drives different `miso` values in the two halves of each bit. It then judges the received word against the half that `smp` selects, checks that `busy` and `ss_n` stay asserted, and checks that the first half of the new word has full length.

// File: rtl/sse_pkg.sv
package sse_pkg;

   typedef enum logic [1:0] {
      WL_8   = 2'd0,
      WL_16  = 2'd1,
      WL_32  = 2'd2,
      WL_32B = 2'd3
   } wlen_e;

   function automatic int unsigned word_bits(input logic [1:0] code);
      case (wlen_e'(code))
         WL_8:    return 8;
         WL_16:   return 16;
         default: return 32;
      endcase
   endfunction

endpackage

// File: rtl/sse_baud.sv
module sse_baud #(
   parameter int DIV_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic             active,
   input  logic [DIV_W-1:0] div_in,
   output logic             half_end
);

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (load) begin
         div_q <= div_in;
         cnt_q <= div_in;
      end else if (active) begin
         cnt_q <= (cnt_q == '0) ? div_q : cnt_q - 1'b1;
      end
   end

   assign half_end = run & active & (cnt_q == '0);

endmodule

// File: rtl/sse_tx_shift.sv
module sse_tx_shift #(
   parameter int MAX_W = 32,
   parameter int SH_W  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             shift,
   input  logic [MAX_W-1:0] data_in,
   input  logic [SH_W-1:0]  shamt,
   output logic             mosi
);

   logic [MAX_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= data_in << shamt;
      end else if (shift) begin
         sh_q <= {sh_q[MAX_W-2:0], 1'b0};
      end
   end

   assign mosi = sh_q[MAX_W-1];

endmodule

// File: rtl/sse_rx_shift.sv
module sse_rx_shift #(
   parameter int MAX_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             sample,
   input  logic             finish,
   input  logic             miso,
   output logic [MAX_W-1:0] rx_data,
   output logic             rx_push
);

   logic [MAX_W-1:0] sh_q;
   logic [MAX_W-1:0] word_now;

   always_comb begin
      word_now = sample ? {sh_q[MAX_W-2:0], miso} : sh_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         rx_data <= '0;
         rx_push <= 1'b0;
      end else begin
         rx_push <= finish;
         if (finish) rx_data <= word_now;
         if (clr) sh_q <= '0;
         else if (sample) sh_q <= {sh_q[MAX_W-2:0], miso};
      end
   end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
   parameter int MAX_W = 32,
   parameter int DIV_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             on_en,
   input  logic             master_mode,
   input  logic             auto_ss,
   input  logic             cpol,
   input  logic             cke,
   input  logic             smp,
   input  logic [1:0]       wlen,
   input  logic [DIV_W-1:0] brg,
   input  logic             tx_valid,
   input  logic [MAX_W-1:0] tx_data,
   output logic             tx_pop,
   output logic [MAX_W-1:0] rx_data,
   output logic             rx_push,
   input  logic             miso,
   output logic             sck,
   output logic             mosi,
   output logic             ss_n,
   output logic             busy
);

   localparam int HALF_W = $clog2(2 * MAX_W);
   localparam int SH_W   = $clog2(MAX_W) + 1;

   generate
      if (MAX_W < 32) begin : g_bad_width
         $error("MAX_W must hold a 32-bit word");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
   endgenerate

   logic              run;
   logic              start;
   logic              half_end;
   logic              word_end;
   logic              active_q;
   logic [HALF_W-1:0] half_q;
   logic [1:0]        wl_q;
   logic              cpol_q, cke_q, smp_q;
   logic [HALF_W:0]   nbits_q;
   logic [HALF_W-1:0] last_half;
   logic [SH_W-1:0]   shamt;

   assign run       = on_en & master_mode;
   assign nbits_q   = (HALF_W+1)'(sse_pkg::word_bits(wl_q));
   assign last_half = HALF_W'({nbits_q, 1'b0} - 1'b1);
   assign word_end  = half_end & (half_q == last_half);
   assign start     = run & tx_valid & (~active_q | word_end);
   assign shamt     = SH_W'(MAX_W - int'(sse_pkg::word_bits(wlen)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         half_q   <= '0;
         wl_q     <= '0;
         cpol_q   <= 1'b0;
         cke_q    <= 1'b0;
         smp_q    <= 1'b0;
      end else if (!run) begin
         active_q <= 1'b0;
         half_q   <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         half_q   <= '0;
         wl_q     <= wlen;
         cpol_q   <= cpol;
         cke_q    <= cke;
         smp_q    <= smp;
      end else if (word_end) begin
         active_q <= 1'b0;
      end else if (half_end) begin
         half_q   <= half_q + 1'b1;
      end
   end

   sse_baud #(.DIV_W(DIV_W)) u_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .load     (start),
      .active   (active_q),
      .div_in   (brg),
      .half_end (half_end)
   );

   sse_tx_shift #(.MAX_W(MAX_W), .SH_W(SH_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start),
      .shift   (half_end & half_q[0]),
      .data_in (tx_data),
      .shamt   (shamt),
      .mosi    (mosi)
   );

   sse_rx_shift #(.MAX_W(MAX_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .sample  (half_end & (half_q[0] == smp_q)),
      .finish  (word_end),
      .miso    (miso),
      .rx_data (rx_data),
      .rx_push (rx_push)
   );

   assign sck    = active_q ? (cpol_q ^ half_q[0] ^ ~cke_q) : cpol;
   assign ss_n   = ~(auto_ss & active_q);
   assign busy   = active_q;
   assign tx_pop = start;

endmodule

// File: rtl/sse_checker.sv
module sse_checker (
   input logic clk,
   input logic rst_n,
   input logic on_en,
   input logic master_mode,
   input logic cpol,
   input logic tx_pop,
   input logic rx_push,
   input logic sck,
   input logic ss_n,
   input logic busy
);

   AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      !(on_en && master_mode) |=> !busy); // R8

   AST_NO_PUSH_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> $past(on_en && master_mode)); // R8

   AST_PUSH_ENDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> $past(busy)); // R5

   AST_POP_STARTS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |=> busy); // R6

   AST_IDLE_SCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy) && $stable(cpol)) |-> $stable(sck)); // R3

   AST_SS_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ss_n); // R7

endmodule

bind spi_shift_engine sse_checker u_chk (.*);

// File: tb/spi_shift_engine_tb.sv
module spi_shift_engine_tb;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n, on_en, master_mode, auto_ss, cpol, cke, smp;
   logic [1:0]  wlen;
   logic [8:0]  brg;
   logic        tx_valid, tx_pop, rx_push, miso, sck, mosi, ss_n, busy;
   logic [31:0] tx_data, rx_data;

   logic [31:0] fifo [0:15];
   int rd = 0, wr = 0;
   assign tx_valid = (wr != rd);
   assign tx_data  = fifo[rd % 16];

   spi_shift_engine u_dut (
      .clk(clk), .rst_n(rst_n), .on_en(on_en), .master_mode(master_mode),
      .auto_ss(auto_ss), .cpol(cpol), .cke(cke), .smp(smp), .wlen(wlen),
      .brg(brg), .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
      .rx_data(rx_data), .rx_push(rx_push), .miso(miso), .sck(sck),
      .mosi(mosi), .ss_n(ss_n), .busy(busy)
   );

   int checks = 0, fails = 0, push_cnt = 0;
   bit finished = 0;

   // per-word tracking state of the bench model
   bit          track = 0, busy_was = 0, sck_prev = 0;
   int          h = 0, cyc = 0, nbits = 8, brg_w = 0;
   logic [31:0] txw, sa, sb;
   bit          cpol_w, cke_w, smp_w;
   bit          pop_pend, p_cpol, p_cke, p_smp;
   logic [31:0] p_data;
   logic [8:0]  p_brg;
   logic [1:0]  p_wl;
   int          jit_hi = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int bits_of(input logic [1:0] c);
      return (c == 2'd0) ? 8 : (c == 2'd1) ? 16 : 32;
   endfunction

   function automatic logic [31:0] mask_w(input logic [31:0] v, input int n);
      return (n >= 32) ? v : (v & ((32'd1 << n) - 1));
   endfunction

   task automatic monitor();
      bit started, new_half;
      logic exp_ss, exp_sck;
      started  = pop_pend;
      new_half = 0;
      if (rx_push) begin
         push_cnt++;
         if (track) chk(rx_data == mask_w(smp_w ? sb : sa, nbits), "R5 rx word",
                        rx_data, mask_w(smp_w ? sb : sa, nbits));
         else chk(0, "R8 push without live word", rx_data, 0);
      end
      exp_ss = auto_ss ? ~busy : 1'b1;
      chk(ss_n == exp_ss, "R7 slave select", ss_n, exp_ss);
      if (!busy) chk(sck == cpol, "R3 idle sck", sck, cpol);
      if (track && busy_was) begin
         if (started || !busy || sck != sck_prev) begin
            chk(cyc == brg_w + 1, "R1 half length", cyc, brg_w + 1);
            if (started || !busy) begin
               chk(h == 2 * nbits - 1, "R2 halves per word", h, 2 * nbits - 1);
               chk(busy == started, "R6 continue or stop", busy, started);
               track = 0;
            end else begin
               h++;
               cyc = 1;
               new_half = 1;
            end
         end else cyc++;
      end
      if (started) begin
         rd++;
         txw = p_data; nbits = bits_of(p_wl); brg_w = int'(p_brg);
         cpol_w = p_cpol; cke_w = p_cke; smp_w = p_smp;
         sa = $urandom; sb = $urandom;
         h = 0; cyc = 1; track = 1; new_half = 1;
         chk(busy, "R6 pop starts word", busy, 1);
      end
      if (track && new_half && h < 2 * nbits) begin
         exp_sck = cpol_w ^ h[0] ^ ~cke_w;
         chk(sck == exp_sck, "R4 sck level", sck, exp_sck);
         chk(mosi == txw[nbits - 1 - h / 2], "R4 mosi bit", mosi, txw[nbits - 1 - h / 2]);
      end
      if (track && h < 2 * nbits) miso = (h % 2 == 0) ? sa[nbits - 1 - h / 2] : sb[nbits - 1 - h / 2];
      else miso = 1'b0;
      sck_prev = sck;
      busy_was = busy;
   endtask

   task automatic step();
      #1;
      pop_pend = tx_pop; p_data = tx_data; p_brg = brg; p_wl = wlen;
      p_cpol = cpol; p_cke = cke; p_smp = smp;
      @(negedge clk);
      monitor();
      if (jit_hi > 0 && ($urandom % 6) == 0) brg = 9'($urandom % (jit_hi + 1));
   endtask

   task automatic push(input logic [31:0] w);
      fifo[wr % 16] = w;
      wr++;
   endtask

   task automatic cfg(input bit cp, input bit ck, input bit sm, input logic [1:0] wl,
                      input int b, input bit ass);
      cpol = cp; cke = ck; smp = sm; wlen = wl; brg = 9'(b); auto_ss = ass;
   endtask

   task automatic run_idle();
      while (busy || tx_valid) step();
      repeat (3) step();
   endtask

   initial begin
      rst_n = 0; on_en = 1; master_mode = 1; miso = 0;
      cfg(1, 1, 0, 2'd0, 0, 1);
      repeat (3) @(negedge clk);
      chk(busy == 0, "R9 busy", busy, 0);
      chk(ss_n == 1, "R9 ss_n", ss_n, 1);
      chk(tx_pop == 0 && rx_push == 0, "R9 pop/push", {tx_pop, rx_push}, 0);
      chk(sck == 1, "R9 sck idle", sck, 1);
      rst_n = 1;
      @(negedge clk);
      busy_was = busy; sck_prev = sck;

      // directed corners
      cfg(0, 1, 0, 2'd0, 0, 1); push(32'hA5);                      run_idle();
      cfg(1, 0, 1, 2'd1, 0, 1); push(32'h1234_C3E1); push(32'h8001); run_idle();
      cfg(0, 1, 1, 2'd0, 0, 1); push(32'h5A); push(32'hFF); push(32'h00); run_idle();
      cfg(0, 0, 0, 2'd2, 1, 0); push(32'hDEAD_BEEF);               run_idle();
      cfg(1, 1, 1, 2'd3, 0, 1); push(32'h8000_0001);               run_idle();
      cfg(0, 1, 0, 2'd0, 511, 1); push(32'h3C);                    run_idle();
      cfg(1, 0, 0, 2'd0, 2, 1); push(32'h96); run_idle(); push(32'h69); run_idle();

      // constrained random, with divider changes during words
      jit_hi = 6;
      for (int it = 0; it < 30; it++) begin
         cfg(1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), int'($urandom % 7), 1'($urandom));
         for (int n = 0; n < 1 + int'($urandom % 3); n++) push($urandom);
         run_idle();
      end
      jit_hi = 0;

      // abort by clearing the on bit in mid word
      cfg(0, 1, 0, 2'd2, 3, 1); push(32'hCAFE_F00D);
      step();
      repeat (20) step();
      chk(busy, "R8 word in flight", busy, 1);
      on_en = 0; track = 0;
      step();
      chk(busy == 0, "R8 abort busy", busy, 0);
      chk(sck == cpol, "R8 abort sck", sck, cpol);
      chk(ss_n == 1, "R8 abort ss_n", ss_n, 1);
      begin
         int pc;
         pc = push_cnt;
         repeat (100) step();
         chk(push_cnt == pc, "R8 no push for aborted word", push_cnt, pc);
      end
      // master mode off holds the engine
      on_en = 1; master_mode = 0; push(32'h77);
      repeat (50) step();
      chk(!busy && tx_valid, "R8 master mode off", {busy, tx_valid}, 2'b01);
      master_mode = 1;
      run_idle();

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule